// File: doc/BRIEF.md
# Pipelined ADC Code Correction

This block turns the raw decision codes of a nine-stage pipelined converter into one corrected 10-bit word per sample. The first eight stages each make a redundant three-level decision, and the ninth is a 2-bit flash. The decisions of one sample arrive one after another, half a sample period apart. The block runs on a clock at twice the sample rate, so each stage code is registered on its own phase. It delays every stage code by enough fast cycles that all nine codes of a sample meet in the same cycle. It then adds them with one-bit overlap between neighbouring stages.

Because neighbouring stages overlap, a decision that lands one level off, caused by a comparator offset inside a quarter of that stage's weight, is repaired by the later stages. No output code goes missing. The converter front end drives the codes and their strobes. The corrected word and its valid flag go to the downstream datapath.

Top module: `pipe_adc_corrector`

## Requirements
- R1: While reset is high and on the first cycle after it, samp_vld is 0, samp_out is 0 and code_err is 0.
- R2: The stage-1 code of a sample is presented at edge T, stage k (k = 1..8) at edge T+k-1, and the flash code at edge T+8. samp_vld is then high for exactly one fast cycle, starting just after edge T+9.
- R3: A residue-stage code is 00, 01 or 10, and the flash code is 0 to 3. Stage k (k = 1..8) has weight 2^(9-k). The corrected word is the sum of stage code times weight plus the flash code, so adjacent 2-bit codes overlap by one bit.
- R4: Ideal decisions produce every output value from 0 to 1023. Ideal decisions mean a stage code of 10 when the remaining signed error is at least half the stage weight, 00 when it is below minus half, and 01 otherwise, with the flash code equal to the final error plus 2.
- R5: When the two decision thresholds of a stage shift by any amount within a quarter of that stage's weight, the corrected word still equals the reference value.
- R6: A new sample may start on every fast cycle, and the samples do not disturb one another.
- R7: samp_vld is raised for a sample only if all nine of its strobes were high. Otherwise samp_vld stays low and samp_out keeps its last value.
- R8: A residue-stage code of 11 presented with its strobe high sets code_err on the next edge, and code_err stays set until reset. A code of 11 with its strobe low has no effect.
- R9: For a sum above 1023, which only a code of 11 can cause, the corrected word saturates at 1023. In that sum, code 11 counts as 3 times the stage weight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, twice the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| stage_code | input | 8x2 | Decision code of each residue stage; element 0 is stage 1 |
| stage_vld | input | 8 | Strobe for each residue-stage code |
| flash_code | input | 2 | Code of the closing 2-bit flash |
| flash_vld | input | 1 | Strobe for the flash code |
| samp_out | output | 10 | Corrected sample word |
| samp_vld | output | 1 | Pulses high for one fast cycle per corrected sample |
| code_err | output | 1 | Sticky flag for an illegal residue-stage code |

## Verification
The assertions assume that reset is high from time zero until at least one edge has passed. They also assume that strobes are only raised after reset is released, so that every value seen through the past operator belongs to the current run. The bench drives stage k of every sample exactly k-1 fast cycles after its stage-1 code, which is the skew the alignment delays are built for. It raises a strobe with an illegal code only in the sticky-error and saturation cases.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

    // Number of redundant residue stages ahead of the closing flash
    localparam int unsigned RES_STAGES = 8;

    // Three-level residue decision, plus the code no stage may emit
    typedef enum logic [1:0] {
        DEC_LO  = 2'b00,
        DEC_MID = 2'b01,
        DEC_HI  = 2'b10,
        DEC_BAD = 2'b11
    } dec_e;

    // One stage code travelling together with its strobe
    typedef struct packed {
        logic       vld;
        logic [1:0] code;
    } slot_t;

    function automatic logic is_illegal(input logic [1:0] c);
        return c == DEC_BAD;
    endfunction

endpackage

// File: rtl/code_screen.sv
module code_screen
    import adc_corr_pkg::*;
#(
    parameter int unsigned LANES = RES_STAGES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LANES-1:0][1:0] code_in,
    input  logic [LANES-1:0]      vld_in,
    output logic                  err_q
);

    logic [LANES-1:0] hit;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign hit[i] = vld_in[i] & is_illegal(code_in[i]);
    end

    // Sticky: once set, only reset clears it
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (|hit) begin
            err_q <= 1'b1;
        end
    end

endmodule

// File: rtl/skew_delay.sv
module skew_delay
    import adc_corr_pkg::*;
#(
    parameter int unsigned DEPTH = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  slot_t din,
    output slot_t dout
);

    // Element 0 is the capture register, the rest realign the skew
    slot_t pipe_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < int'(DEPTH); k++) begin
                pipe_q[k] <= '0;
            end
        end else begin
            pipe_q[0] <= din;
            for (int k = 1; k < int'(DEPTH); k++) begin
                pipe_q[k] <= pipe_q[k-1];
            end
        end
    end

    assign dout = pipe_q[DEPTH-1];

endmodule

// File: rtl/overlap_adder.sv
module overlap_adder
    import adc_corr_pkg::*;
#(
    parameter int unsigned RES_STG = RES_STAGES,
    parameter int unsigned OUT_W   = RES_STG + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  slot_t [RES_STG-1:0]     res_al,
    input  slot_t                   fl_al,
    output logic  [OUT_W-1:0]       word_q,
    output logic                    vld_q
);

    localparam int unsigned SUM_W    = OUT_W + 1;
    localparam int unsigned MAX_CODE = (1 << OUT_W) - 1;

    logic [SUM_W-1:0] term [RES_STG];
    logic [SUM_W-1:0] acc;
    logic [OUT_W-1:0] sat;
    logic             all_vld;

    // Stage i (0-based) carries weight 2^(RES_STG-i); neighbours overlap by one bit
    for (genvar i = 0; i < RES_STG; i++) begin : g_term
        assign term[i] = SUM_W'(res_al[i].code) << (RES_STG - i);
    end

    always_comb begin
        acc     = SUM_W'(fl_al.code);
        all_vld = fl_al.vld;
        for (int i = 0; i < int'(RES_STG); i++) begin
            acc     = acc + term[i];
            all_vld = all_vld & res_al[i].vld;
        end
    end

    assign sat = (acc > SUM_W'(MAX_CODE)) ? OUT_W'(MAX_CODE) : acc[OUT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= all_vld;
            if (all_vld) begin
                word_q <= sat;
            end
        end
    end

endmodule

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector
    import adc_corr_pkg::*;
#(
    parameter  int unsigned RES_STG = RES_STAGES,
    localparam int unsigned OUT_W   = RES_STG + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [RES_STG-1:0][1:0] stage_code,
    input  logic [RES_STG-1:0]      stage_vld,
    input  logic [1:0]              flash_code,
    input  logic                    flash_vld,
    output logic [OUT_W-1:0]        samp_out,
    output logic                    samp_vld,
    output logic                    code_err
);

    slot_t [RES_STG-1:0] res_al;
    slot_t               fl_al;
    slot_t               fl_in;

    // Stage i arrives i fast cycles after stage 0, so it waits RES_STG-i more
    for (genvar i = 0; i < RES_STG; i++) begin : g_lane
        slot_t lane_in;
        assign lane_in.vld  = stage_vld[i];
        assign lane_in.code = stage_code[i];

        skew_delay #(
            .DEPTH(RES_STG - i + 1)
        ) u_dly (
            .clk  (clk),
            .rst  (rst),
            .din  (lane_in),
            .dout (res_al[i])
        );
    end

    assign fl_in.vld  = flash_vld;
    assign fl_in.code = flash_code;

    skew_delay #(
        .DEPTH(1)
    ) u_fl_dly (
        .clk  (clk),
        .rst  (rst),
        .din  (fl_in),
        .dout (fl_al)
    );

    overlap_adder #(
        .RES_STG(RES_STG),
        .OUT_W  (OUT_W)
    ) u_add (
        .clk    (clk),
        .rst    (rst),
        .res_al (res_al),
        .fl_al  (fl_al),
        .word_q (samp_out),
        .vld_q  (samp_vld)
    );

    code_screen #(
        .LANES(RES_STG)
    ) u_screen (
        .clk     (clk),
        .rst     (rst),
        .code_in (stage_code),
        .vld_in  (stage_vld),
        .err_q   (code_err)
    );

endmodule

// File: rtl/adc_corr_checker.sv
module adc_corr_checker #(
    parameter int unsigned RES_STG = 8,
    parameter int unsigned OUT_W   = RES_STG + 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic [RES_STG-1:0][1:0] stage_code,
    input logic [RES_STG-1:0]      stage_vld,
    input logic                    flash_vld,
    input logic [OUT_W-1:0]        samp_out,
    input logic                    samp_vld,
    input logic                    code_err
);

    logic rst_d;
    logic bad_now;

    always_ff @(posedge clk) begin
        rst_d <= rst;
    end

    always_comb begin
        bad_now = 1'b0;
        for (int i = 0; i < int'(RES_STG); i++) begin
            bad_now = bad_now | (stage_vld[i] & (stage_code[i] == 2'b11));
        end
    end

    // R1: outputs sit at their reset values after any edge that saw reset
    always @(negedge clk) begin
        if (rst_d) begin
            assert_reset_state_R1: assert (!samp_vld && samp_out == '0 && !code_err)
                else $error("reset state violated");
        end
    end

    // R7: a word is only produced when the flash strobe was captured two edges earlier
    assert_vld_needs_flash_R7: assert property (@(posedge clk) disable iff (rst)
        samp_vld |-> $past(flash_vld, 2));

    // R7: without a valid strobe the output word holds
    assert_hold_word_R7: assert property (@(posedge clk) disable iff (rst)
        !samp_vld |-> $stable(samp_out));

    // R8: an illegal strobed code raises the error flag on the next edge
    assert_err_set_R8: assert property (@(posedge clk) disable iff (rst)
        bad_now |=> code_err);

    // R8: the error flag never clears on its own
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        code_err |=> code_err);

endmodule

bind pipe_adc_corrector adc_corr_checker #(
    .RES_STG(RES_STG)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .stage_code (stage_code),
    .stage_vld  (stage_vld),
    .flash_vld  (flash_vld),
    .samp_out   (samp_out),
    .samp_vld   (samp_vld),
    .code_err   (code_err)
);

// File: tb/pipe_adc_corrector_test.sv
module pipe_adc_corrector_test;

    localparam int CLK_PERIOD = 10;
    localparam int RS         = 8;
    localparam int LANES      = RS + 1;
    localparam int OW         = RS + 2;
    localparam int MAXS       = 1024;
    localparam int TOP        = (1 << OW) - 1;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [RS-1:0][1:0] stage_code = '0;
    logic [RS-1:0]      stage_vld  = '0;
    logic [1:0]         flash_code = '0;
    logic               flash_vld  = 1'b0;
    logic [OW-1:0]      samp_out;
    logic               samp_vld;
    logic               code_err;

    pipe_adc_corrector #(.RES_STG(RS)) uut (
        .clk        (clk),
        .rst        (rst),
        .stage_code (stage_code),
        .stage_vld  (stage_vld),
        .flash_code (flash_code),
        .flash_vld  (flash_vld),
        .samp_out   (samp_out),
        .samp_vld   (samp_vld),
        .code_err   (code_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [1:0] sc [MAXS][LANES];
    logic       sv [MAXS][LANES];
    int         ref_v [MAXS];
    int         exp_q [$];
    int         n_checks = 0;
    int         n_fail = 0;
    int         out_count = 0;
    int         cyc = 0;
    int         t_start = 0;
    int         t_last = 0;
    string      cur_tag = "R1";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // R3: sum of code times 2^(RS-s) plus flash, capped at TOP (R9)
    function automatic int formula(input int idx);
        int acc = int'(sc[idx][RS]);
        for (int s = 0; s < RS; s++) acc += int'(sc[idx][s]) * (1 << (RS - s));
        return (acc > TOP) ? TOP : acc;
    endfunction

    // Ideal or offset decisions derived from a reference value (R4, R5)
    task automatic gen_ref(input int idx, input int v, input bit use_off);
        int e = v - (1 << (OW - 1));
        int w;
        int off;
        int d;
        for (int s = 0; s < RS; s++) begin
            w = 1 << (RS - s);
            off = 0;
            if (use_off && w >= 8) off = int'($urandom_range(w / 2)) - w / 4;
            if (e >= w / 2 + off) d = 1;
            else if (e < -(w / 2) + off) d = -1;
            else d = 0;
            e = e - d * w;
            sc[idx][s] = 2'(d + 1);
            sv[idx][s] = 1'b1;
        end
        sc[idx][RS] = 2'(e + 2);
        sv[idx][RS] = 1'b1;
        ref_v[idx] = v;
    endtask

    task automatic fill(input int idx, input logic [1:0] c, input logic [1:0] f);
        for (int s = 0; s < RS; s++) begin
            sc[idx][s] = c;
            sv[idx][s] = 1'b1;
        end
        sc[idx][RS] = f;
        sv[idx][RS] = 1'b1;
        ref_v[idx] = -1;
    endtask

    // Driver: stage s of sample k presented k*spacing+s cycles after start
    task automatic play(input int n, input int spacing);
        int last = (n - 1) * spacing + RS;
        for (int k = 0; k < n; k++) begin
            bit full = 1'b1;
            for (int s = 0; s < LANES; s++) full &= sv[k][s];
            if (full) exp_q.push_back((ref_v[k] >= 0) ? ref_v[k] : formula(k));
        end
        for (int c = 0; c <= last; c++) begin
            @(negedge clk);
            if (c == 0) t_start = cyc;
            for (int s = 0; s < LANES; s++) begin
                int rel = c - s;
                logic [1:0] cd = 2'b00;
                logic vv = 1'b0;
                if (rel >= 0 && (rel % spacing) == 0 && (rel / spacing) < n) begin
                    cd = sc[rel / spacing][s];
                    vv = sv[rel / spacing][s];
                end
                if (s < RS) begin
                    stage_code[s] = cd;
                    stage_vld[s]  = vv;
                end else begin
                    flash_code = cd;
                    flash_vld  = vv;
                end
            end
        end
        @(negedge clk);
        stage_code = '0;
        stage_vld  = '0;
        flash_code = '0;
        flash_vld  = 1'b0;
        repeat (14) @(negedge clk);
    endtask

    // Monitor: scoreboard pops and compares each produced word
    always @(negedge clk) begin
        if (!rst && samp_vld) begin
            out_count++;
            t_last = cyc;
            if (exp_q.size() == 0) begin
                check({cur_tag, " R7 unexpected word"}, int'(samp_out), -1);
            end else begin
                check(cur_tag, int'(samp_out), exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check("R2 watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int base;
        int held;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 vld in reset", int'(samp_vld), 0);
        check("R1 word in reset", int'(samp_out), 0);
        check("R1 err in reset", int'(code_err), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 vld after reset", int'(samp_vld), 0);
        check("R1 err after reset", int'(code_err), 0);

        // R2: alignment and latency for one sample
        cur_tag = "R2";
        base = out_count;
        gen_ref(0, 700, 1'b0);
        play(1, 2);
        check("R2 word count", out_count - base, 1);
        check("R2 latency in fast cycles", t_last - t_start, 10);

        // R3: directed code patterns against the weighting rule
        cur_tag = "R3";
        fill(0, 2'b01, 2'b00);                     // 510
        fill(1, 2'b00, 2'b00);                     // 0, lower rail
        fill(2, 2'b10, 2'b11);                     // 1023, upper legal rail
        fill(3, 2'b00, 2'b11);
        for (int s = 0; s < RS; s += 2) sc[3][s] = 2'b10;  // 683
        fill(4, 2'b00, 2'b01);
        sc[4][RS-1] = 2'b10;                       // 5
        play(5, 2);
        check("R3 queue drained", exp_q.size(), 0);

        // R4: every output code from ideal decisions
        cur_tag = "R4";
        base = out_count;
        for (int v = 0; v < MAXS; v++) gen_ref(v, v, 1'b0);
        play(MAXS, 2);
        check("R4 all codes produced", out_count - base, MAXS);
        check("R4 no false error", int'(code_err), 0);

        // R5: threshold offsets inside a quarter weight
        cur_tag = "R5";
        base = out_count;
        for (int k = 0; k < 600; k++) gen_ref(k, int'($urandom_range(TOP)), 1'b1);
        play(600, 2);
        check("R5 word count", out_count - base, 600);

        // R6: one new sample on every fast cycle
        cur_tag = "R6";
        base = out_count;
        for (int k = 0; k < 300; k++) gen_ref(k, (k * 337 + 11) % (TOP + 1), 1'b1);
        play(300, 1);
        check("R6 word count", out_count - base, 300);
        check("R6 queue drained", exp_q.size(), 0);

        // R7: a missing strobe drops that sample only
        cur_tag = "R7";
        base = out_count;
        gen_ref(0, 100, 1'b0);
        gen_ref(1, 200, 1'b0);
        sv[1][3] = 1'b0;
        gen_ref(2, 300, 1'b0);
        play(3, 2);
        check("R7 words with gap", out_count - base, 2);
        held = int'(samp_out);
        base = out_count;
        gen_ref(0, 900, 1'b0);
        sv[0][RS] = 1'b0;
        play(1, 2);
        check("R7 no word for dropped sample", out_count - base, 0);
        check("R7 word held", int'(samp_out), held);

        // R8: illegal code without strobe is ignored
        cur_tag = "R8";
        gen_ref(0, 400, 1'b0);
        sc[0][2] = 2'b11;
        sv[0][2] = 1'b0;
        play(1, 2);
        check("R8 unstrobed illegal ignored", int'(code_err), 0);

        // R8: strobed illegal code sets the sticky flag
        fill(0, 2'b00, 2'b00);
        sc[0][1] = 2'b11;                          // 3*128 = 384
        play(1, 2);
        check("R8 error set", int'(code_err), 1);
        gen_ref(0, 512, 1'b0);
        play(1, 2);
        check("R8 error sticky", int'(code_err), 1);

        // R9: saturation at the upper rail
        cur_tag = "R9";
        base = out_count;
        fill(0, 2'b11, 2'b11);                     // 1533 -> 1023
        fill(1, 2'b00, 2'b00);
        sc[1][0] = 2'b11;
        sc[1][1] = 2'b11;                          // 1152 -> 1023
        fill(2, 2'b00, 2'b10);
        sc[2][0] = 2'b11;                          // 770, no cap
        play(3, 2);
        check("R9 word count", out_count - base, 3);
        check("R9 last word", int'(samp_out), 770);
        check("R9 queue drained", exp_q.size(), 0);

        finish_run();
    end

endmodule